// File: doc/BRIEF.md
# Exact Reciprocal Square Root Search Unit

This block finds the fixed-point reciprocal square root of an unsigned operand `a` by deciding one result bit per trial. It keeps the largest root `x` found so far, together with the exact products `a·x²` and `a·x`. It tries `x + 2^b` for b = -1, -2, … down to the last fraction bit. The candidate square is built from the running values with shifts and adds alone: a·(x+2^b)² = a·x² + a·x·2^(b+1) + a·2^(2b). A trial is kept only when the candidate product does not exceed 1.0. Because every term is held at full precision, the block also returns the exact remainder 1 − a·x². A rounding stage further downstream can use it to round correctly.

The operand arrives over a valid/ready handshake and the result leaves over a second one. The block takes one job at a time. The search starts from x = 1.0, which is always admissible for the supported operand range. By default one trial is done per clock, and a parameter can chain several trial units into a single cycle. Unpacking of floating-point operands, normalisation and special values belong to other blocks.

Top module: `rsqrt_search`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1 and `out_valid` is 0.
- R2: An operand is taken on a clock edge where `in_valid` and `in_ready` are both 1. From that edge until the result has been taken, `in_ready` stays 0.
- R3: `a_in` is read as a number with 1 integer bit and AF fraction bits, and must lie in (0.25, 1.0]. `x_out` is read as 1 integer bit (its MSB) and W fraction bits. For such an operand the result satisfies a·x² ≤ 1.
- R4: The result is maximal: a·(x + 2^-W)² > 1, so `x_out` equals the largest W-fraction-bit value meeting R3.
- R5: `rem_out` equals exactly 1 − a·x², counted in units of 2^-(AF+2W).
- R6: `out_valid` rises ceil(W/STEPS) clock edges after the edge that took the operand.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `x_out` and `rem_out` hold their values. The result is released on the edge where both are 1.
- R8: An operand of exactly 1.0 gives x = 1.0 (only the MSB of `x_out` set) and a remainder of 0.
- R9: `in_valid` pulses while a job is in flight are ignored. They change neither that job's result nor start a further job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block idle and able to take an operand |
| a_in | input | AF+1 | Operand, 1 integer bit and AF fraction bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| x_out | output | W+1 | Root, 1 integer bit and W fraction bits |
| rem_out | output | AF+2W+1 | Exact 1 − a·x² in units of 2^-(AF+2W) |

## Verification
A wrong accept decision or a misaligned shift in a trial corrupts the running square. That shows at the ports the moment the result is offered, as a root that either breaks a·x² ≤ 1 or is not the largest such value, or as a remainder that disagrees with 1 − a·x². Every operand in the supported range at the default width is driven, so every accept/reject pattern of the bit search is reached. Latency faults appear at the first result as a rise of `out_valid` on the wrong edge. Handshake faults appear within a cycle of a held-off consumer, as a result that changes or vanishes.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_RUN  = 2'd1,
        RS_DONE = 2'd2
    } rs_state_e;

endpackage

// File: rtl/rsqrt_trial.sv
// One bit decision of the search: tries x + 2^-k and keeps it if a*(x+2^-k)^2 <= 1.
module rsqrt_trial #(
    parameter int W  = 8,
    parameter int AF = 8,
    parameter int KW = 4
) (
    input  logic [AF:0]          a_i,
    input  logic [W:0]           x_i,
    input  logic [AF+2*W+2:0]    sq_i,
    input  logic [AF+W+1:0]      ax_i,
    input  logic [KW-1:0]        k_i,
    output logic [W:0]           x_o,
    output logic [AF+2*W+2:0]    sq_o,
    output logic [AF+W+1:0]      ax_o
);
    localparam int XW  = W + 1;
    localparam int SQW = AF + 2*W + 3;
    localparam int AXW = AF + W + 2;
    localparam logic [SQW-1:0] ONE = SQW'(1) << (AF + 2*W);

    logic           en;
    logic           take;
    int             kk;
    logic [SQW-1:0] cand;

    always_comb begin
        en   = (int'(k_i) >= 1) && (int'(k_i) <= W);
        kk   = en ? int'(k_i) : W;
        // a*x*2^(1-k) and a*2^(-2k), both aligned to 2^-(AF+2W)
        cand = sq_i + (SQW'(ax_i) << (W + 1 - kk)) + (SQW'(a_i) << (2*W - 2*kk));
        take = en && (cand <= ONE);
        x_o  = take ? (x_i | (XW'(1) << (W - kk))) : x_i;
        sq_o = take ? cand : sq_i;
        ax_o = take ? (ax_i + (AXW'(a_i) << (W - kk))) : ax_i;
    end

endmodule

// File: rtl/rsqrt_seq.sv
// Job sequencer: idle / searching / holding result, plus the trial index.
module rsqrt_seq
    import rsqrt_pkg::*;
#(
    parameter int W     = 8,
    parameter int STEPS = 1,
    parameter int KW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          load,
    output logic          run,
    output logic [KW-1:0] k
);
    localparam int NCYC = (W + STEPS - 1) / STEPS;

    typedef struct packed {
        rs_state_e     st;
        logic [KW-1:0] k;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            RS_IDLE: begin
                if (in_valid) begin
                    seq_d.st = RS_RUN;
                    seq_d.k  = KW'(1);
                end
            end
            RS_RUN: begin
                seq_d.k = seq_q.k + KW'(STEPS);
                if (int'(seq_q.k) + STEPS > W) seq_d.st = RS_DONE;
            end
            RS_DONE: begin
                if (out_ready) seq_d.st = RS_IDLE;
            end
            default: seq_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= RS_IDLE;
            seq_q.k  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_ready  = (seq_q.st == RS_IDLE);
    assign out_valid = (seq_q.st == RS_DONE);
    assign load      = in_ready && in_valid;
    assign run       = (seq_q.st == RS_RUN);
    assign k         = seq_q.k;

    // cycle count since the operand was taken, for the latency check
    logic [KW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= '0;
        else if (load)   lat_q <= '0;
        else if (run)    lat_q <= lat_q + KW'(1);
    end

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (int'(lat_q) == NCYC));

    assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(k) >= 1 && int'(k) <= W));

endmodule

// File: rtl/rsqrt_search.sv
module rsqrt_search
    import rsqrt_pkg::*;
#(
    parameter int W     = 8,
    parameter int AF    = 8,
    parameter int STEPS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [AF:0]        a_in,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [W:0]         x_out,
    output logic [AF+2*W:0]    rem_out
);
    localparam int AW  = AF + 1;
    localparam int XW  = W + 1;
    localparam int SQW = AF + 2*W + 3;
    localparam int AXW = AF + W + 2;
    localparam int RW  = AF + 2*W + 1;
    localparam int KW  = $clog2(W + STEPS + 1);
    localparam logic [SQW-1:0] ONE = SQW'(1) << (AF + 2*W);

    typedef struct packed {
        logic [AW-1:0]  a;
        logic [XW-1:0]  x;
        logic [SQW-1:0] sq;
        logic [AXW-1:0] ax;
    } dp_t;

    dp_t dp_d, dp_q;

    logic          load;
    logic          run;
    logic [KW-1:0] k_q;

    rsqrt_seq #(.W(W), .STEPS(STEPS), .KW(KW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .run       (run),
        .k         (k_q)
    );

    // chain of trial units, STEPS per clock
    logic [XW-1:0]  xc  [STEPS+1];
    logic [SQW-1:0] sqc [STEPS+1];
    logic [AXW-1:0] axc [STEPS+1];

    assign xc[0]  = dp_q.x;
    assign sqc[0] = dp_q.sq;
    assign axc[0] = dp_q.ax;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        rsqrt_trial #(.W(W), .AF(AF), .KW(KW)) u_trial (
            .a_i  (dp_q.a),
            .x_i  (xc[g]),
            .sq_i (sqc[g]),
            .ax_i (axc[g]),
            .k_i  (k_q + KW'(g)),
            .x_o  (xc[g+1]),
            .sq_o (sqc[g+1]),
            .ax_o (axc[g+1])
        );
    end

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.a  = a_in;
            dp_d.x  = XW'(1) << W;             // x = 1.0
            dp_d.sq = SQW'(a_in) << (2*W);     // a * 1.0^2
            dp_d.ax = AXW'(a_in) << W;         // a * 1.0
        end else if (run) begin
            dp_d.x  = xc[STEPS];
            dp_d.sq = sqc[STEPS];
            dp_d.ax = axc[STEPS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign x_out   = dp_q.x;
    assign rem_out = RW'(ONE - dp_q.sq);

    assert_square_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dp_q.sq <= ONE));

    assert_root_at_least_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> x_out[W]);

    assert_linear_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dp_q.ax == AXW'(AXW'(dp_q.a) * AXW'(dp_q.x))));

    assert_square_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dp_q.sq == SQW'(SQW'(dp_q.a) * SQW'(dp_q.x) * SQW'(dp_q.x))));

    assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(x_out) && $stable(rem_out)));

endmodule

// File: tb/test_rsqrt_search.sv
module test_rsqrt_search;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int AF   = 8;
    localparam int S    = 1;
    localparam int NCYC = (W + S - 1) / S;
    localparam longint ONE = 64'sd1 <<< (AF + 2*W);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [AF:0]        a_in = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [W:0]         x_out;
    logic [AF+2*W:0]    rem_out;

    rsqrt_search #(.W(W), .AF(AF), .STEPS(S)) i_rsqrt_search (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a_in(a_in), .out_valid(out_valid), .out_ready(out_ready),
        .x_out(x_out), .rem_out(rem_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        longint a;
        longint x;
        longint rem;
        bit     stall;
    } exp_t;

    exp_t   q[$];
    int     checks = 0;
    int     fails  = 0;
    int     sent   = 0;
    int     got    = 0;
    longint cyc    = 0;
    longint acc_cyc = 0;
    bit     held   = 0;
    int     vcnt   = 0;
    longint last_x = 0;
    longint last_rem = 0;
    exp_t   cur;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint best_x(longint a);
        for (longint x = (64'sd1 <<< (W+1)) - 1; x >= 0; x--)
            if (a * x * x <= ONE) return x;
        return 0;
    endfunction

    // driver: offers one operand and queues its expected result
    task automatic send(longint a, bit stall);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        a_in     = (AF+1)'(a);
        while (!in_ready) @(negedge clk);
        e.a = a; e.x = best_x(a); e.rem = ONE - a * e.x * e.x; e.stall = stall;
        acc_cyc = cyc + 1;
        q.push_back(e);
        @(posedge clk);
        #1 in_valid = 1'b0;
        sent++;
        @(negedge clk);
        check(in_ready == 1'b0, "R2 busy", longint'(in_ready), 0);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (!held) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R9 unexpected result", longint'(x_out), -1);
                        cur.stall = 0;
                    end else begin
                        cur = q[0];
                        check(cyc == acc_cyc + NCYC, "R6 latency", cyc - acc_cyc, NCYC);
                        check(cur.a * longint'(x_out) * longint'(x_out) <= ONE, "R3 bound",
                              longint'(x_out), cur.x);
                        check(cur.a * (longint'(x_out)+1) * (longint'(x_out)+1) > ONE, "R4 maximal",
                              longint'(x_out), cur.x);
                        check(longint'(x_out) == cur.x, "R3 R4 root", longint'(x_out), cur.x);
                        check(longint'(rem_out) == cur.rem, "R5 remainder", longint'(rem_out), cur.rem);
                        if (cur.a == (64'sd1 <<< AF)) begin
                            check(longint'(x_out) == (64'sd1 <<< W), "R8 unit root",
                                  longint'(x_out), 64'sd1 <<< W);
                            check(rem_out == '0, "R8 zero remainder", longint'(rem_out), 0);
                        end
                    end
                    vcnt = 0;
                end else begin
                    check(longint'(x_out) == last_x, "R7 root held", longint'(x_out), last_x);
                    check(longint'(rem_out) == last_rem, "R7 remainder held", longint'(rem_out), last_rem);
                end
                last_x   = longint'(x_out);
                last_rem = longint'(rem_out);
                out_ready = !(cur.stall && vcnt < 3);
                vcnt++;
                if (out_ready) begin
                    if (q.size() != 0) void'(q.pop_front());
                    got++;
                    held = 0;
                end else begin
                    held = 1;
                end
            end else begin
                if (held) begin
                    check(1'b0, "R7 valid dropped", 0, 1);
                    held = 0;
                end
                out_ready = 1'b1;
            end
        end
    end

    initial begin
        #(longint'(CLK_PERIOD) * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);

        // R8: operand exactly 1.0
        send(64'sd1 <<< AF, 1'b0);

        // R9: extra in_valid pulses while busy are ignored
        send(180, 1'b0);
        in_valid = 1'b1;
        a_in     = (AF+1)'(77);
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (3 * NCYC) @(negedge clk);
        check(got == sent, "R9 job count", got, sent);
        check(out_valid == 1'b0, "R9 no extra result", longint'(out_valid), 0);

        // R3 R4 R5 R6 R7: every operand in (0.25, 1.0], some with a held-off consumer
        for (int v = (1 << (AF-2)) + 1; v <= (1 << AF); v++)
            send(v, (v % 3) == 0);

        while (q.size() != 0) @(negedge clk);
        repeat (2 * NCYC) @(negedge clk);
        check(got == sent, "R2 all results delivered", got, sent);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule